// File: doc/BRIEF.md
# PS/2 Keyboard Numeral Display

This block listens to a keyboard on a PS/2 clock and data pair, rebuilds each 11-bit frame and recovers the 8-bit scan code. When the code belongs to one of the number keys "0" to "9" (keyboard scan code set 2), a seven-segment digit is driven to show that numeral. A one-cycle strobe marks each accepted digit.

Both raw lines are brought into the system clock domain by flop synchronisers, and a bit is taken on each falling edge of the synchronised PS/2 clock. Frames with a wrong start, parity or stop bit are thrown away. Valid codes that are not digits are also ignored, as is the byte that follows the 0xF0 release prefix. If a frame stalls partway, an idle timer drops the partial frame so the receiver can lock onto the next one. The last accepted numeral stays on the display.

Top module: `ps2_digit_display`

## Requirements
- R1: A frame is taken bit by bit on each high-to-low change of the synchronised PS/2 clock: start bit (0), eight data bits with the least significant bit first, parity bit, stop bit (1).
- R2: Output `seg` maps bit 0 to segment A through bit 6 to segment G, active high. Accepted codes drive: 0x45 -> 0x3F ("0"), 0x16 -> 0x06, 0x1E -> 0x5B, 0x26 -> 0x4F, 0x25 -> 0x66, 0x2E -> 0x6D, 0x36 -> 0x7D, 0x3D -> 0x07, 0x3E -> 0x7F, 0x46 -> 0x6F ("9").
- R3: A frame whose start bit is 1, whose stop bit is 0, or whose nine data-plus-parity bits hold an even count of ones is dropped. `seg` does not change and no strobe is given.
- R4: A valid frame whose code is not one of the ten digit codes leaves `seg` unchanged and gives no strobe.
- R5: The valid frame that follows a valid 0xF0 frame is ignored, even when it carries a digit code.
- R6: If no PS/2 clock falling edge arrives for IDLE_US microseconds while a frame is partly received, the partial frame is discarded and the next falling edge is treated as a start bit.
- R7: `digit_strobe` is high for exactly one cycle for each accepted digit, in the same cycle as the new `seg` value first appears.
- R8: While reset is held, `seg` is 0 and `digit_strobe` is low. Outside reset, `seg` changes only with a strobe, so the last accepted numeral is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ps2_clk_raw | input | 1 | PS/2 clock line from the keyboard, asynchronous |
| ps2_dat_raw | input | 1 | PS/2 data line from the keyboard, asynchronous |
| seg | output | 7 | Segment lines, bit 0 = A through bit 6 = G, active high |
| digit_strobe | output | 1 | One-cycle pulse for each accepted digit |

## Verification
All ten digit codes are sent, and each has a different bit pattern, so a wrong bit order or a wrong segment table shows up as a mismatch in the scoreboard. Frames spoiled in only one of the three ways (parity, start, stop) show which check was dropped. A non-digit code and a release sequence (0xF0 followed by a digit) separate code filtering from break handling. A truncated frame followed by a long pause and then a good digit only decodes correctly if the idle timeout has realigned the bit counter.

// File: rtl/ps2dd_pkg.sv
package ps2dd_pkg;
   localparam int SEG_W      = 7;
   localparam int CODE_W     = 8;
   localparam int FRAME_BITS = 11;

   typedef logic [SEG_W-1:0]  seg_t;
   typedef logic [CODE_W-1:0] code_t;

   typedef struct packed {
      logic hit;
      seg_t pattern;
   } digit_hit_t;

   localparam code_t BREAK_CODE = 8'hF0;

   // Segment order: bit 0 = A ... bit 6 = G, active high.
   function automatic digit_hit_t lookup_code(input code_t c);
      digit_hit_t r;
      r.hit = 1'b1;
      case (c)
         8'h45:   r.pattern = 7'h3F;
         8'h16:   r.pattern = 7'h06;
         8'h1E:   r.pattern = 7'h5B;
         8'h26:   r.pattern = 7'h4F;
         8'h25:   r.pattern = 7'h66;
         8'h2E:   r.pattern = 7'h6D;
         8'h36:   r.pattern = 7'h7D;
         8'h3D:   r.pattern = 7'h07;
         8'h3E:   r.pattern = 7'h7F;
         8'h46:   r.pattern = 7'h6F;
         default: begin
            r.hit     = 1'b0;
            r.pattern = '0;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/ps2dd_sync.sv
module ps2dd_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ps2dd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ps2dd_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2dd_frame_rx.sv
module ps2dd_frame_rx
   import ps2dd_pkg::*;
#(
   parameter int TIMEOUT_CYC = 5000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  kb_clk,
   input  logic  kb_dat,
   output logic  frame_ok,
   output code_t code
);
   localparam int CNT_W  = $clog2(FRAME_BITS);
   localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

   generate
      if (TIMEOUT_CYC < 16) begin : g_bad_timeout
         $error("ps2dd_frame_rx: TIMEOUT_CYC too small");
      end
   endgenerate

   logic                  kb_clk_q;
   logic                  fall;
   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic [FRAME_BITS-1:0] next_word;
   logic [IDLE_W-1:0]     idle_cnt;
   logic                  word_good;

   assign fall      = kb_clk_q & ~kb_clk;
   assign next_word = {kb_dat, shreg[FRAME_BITS-1:1]};
   // word: [0]=start, [8:1]=data, [9]=parity, [10]=stop
   assign word_good = ~next_word[0] & next_word[FRAME_BITS-1] & (^next_word[9:1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kb_clk_q <= 1'b1;
         bit_cnt  <= '0;
         shreg    <= '0;
         idle_cnt <= '0;
         frame_ok <= 1'b0;
         code     <= '0;
      end else begin
         kb_clk_q <= kb_clk;
         frame_ok <= 1'b0;
         if (fall) begin
            idle_cnt <= '0;
            shreg    <= next_word;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               frame_ok <= word_good;
               code     <= next_word[8:1];
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (bit_cnt != '0) begin
            if (idle_cnt == IDLE_W'(TIMEOUT_CYC - 1)) begin
               bit_cnt  <= '0;
               idle_cnt <= '0;
            end else begin
               idle_cnt <= idle_cnt + 1'b1;
            end
         end else begin
            idle_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/ps2dd_code_map.sv
module ps2dd_code_map
   import ps2dd_pkg::*;
(
   input  code_t code,
   output logic  hit,
   output seg_t  pattern
);
   digit_hit_t r;
   assign r       = lookup_code(code);
   assign hit     = r.hit;
   assign pattern = r.pattern;
endmodule

// File: rtl/ps2_digit_display.sv
module ps2_digit_display
   import ps2dd_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int IDLE_US     = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ps2_clk_raw,
   input  logic       ps2_dat_raw,
   output logic [6:0] seg,
   output logic       digit_strobe
);
   localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * IDLE_US;

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("ps2_digit_display: CLK_HZ must be at least 1 MHz");
      end
   endgenerate

   logic [1:0] lines_s;
   logic       frame_ok;
   code_t      code;
   logic       hit;
   seg_t       pattern;
   logic       after_break;

   ps2dd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ps2_dat_raw, ps2_clk_raw}),
      .q     (lines_s)
   );

   ps2dd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .kb_clk   (lines_s[0]),
      .kb_dat   (lines_s[1]),
      .frame_ok (frame_ok),
      .code     (code)
   );

   ps2dd_code_map u_map (
      .code    (code),
      .hit     (hit),
      .pattern (pattern)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg          <= '0;
         digit_strobe <= 1'b0;
         after_break  <= 1'b0;
      end else begin
         digit_strobe <= 1'b0;
         if (frame_ok) begin
            if (after_break) begin
               after_break <= 1'b0;
            end else if (code == BREAK_CODE) begin
               after_break <= 1'b1;
            end else if (hit) begin
               seg          <= pattern;
               digit_strobe <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ps2_digit_display_chk.sv
module ps2_digit_display_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [6:0] seg,
   input logic       digit_strobe,
   input logic       frame_ok,
   input logic       hit
);
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      digit_strobe |=> !digit_strobe); // R7

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !digit_strobe |-> $stable(seg)); // R8

   AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      digit_strobe |-> (seg inside {7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                    7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F})); // R2

   AST_RESET_DARK: assert property (@(posedge clk)
      !rst_n |=> (seg == 7'h00 && !digit_strobe)); // R8

   AST_DROP_NONDIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && !hit) |=> !digit_strobe); // R4

   AST_STROBE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      digit_strobe |-> $past(frame_ok)); // R3
endmodule

bind ps2_digit_display ps2_digit_display_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .seg          (seg),
   .digit_strobe (digit_strobe),
   .frame_ok     (frame_ok),
   .hit          (hit)
);

// File: tb/ps2_digit_display_tb_top.sv
module ps2_digit_display_tb_top;
   localparam int HALF = 20;  // system cycles per PS/2 half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ps2c = 1'b1;
   logic       ps2d = 1'b1;
   logic [6:0] seg;
   logic       strobe;

   int checks = 0;
   int fails  = 0;
   logic [6:0] exp_q[$];
   logic [6:0] last_seg = 7'h00;
   logic       model_break = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   ps2_digit_display dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ps2_clk_raw  (ps2c),
      .ps2_dat_raw  (ps2d),
      .seg          (seg),
      .digit_strobe (strobe)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_pattern(input logic [7:0] c, output logic is_digit);
      is_digit = 1'b1;
      case (c)
         8'h45: return 8'h3F;  8'h16: return 8'h06;
         8'h1E: return 8'h5B;  8'h26: return 8'h4F;
         8'h25: return 8'h66;  8'h2E: return 8'h6D;
         8'h36: return 8'h7D;  8'h3D: return 8'h07;
         8'h3E: return 8'h7F;  8'h46: return 8'h6F;
         default: begin is_digit = 1'b0; return 8'h00; end
      endcase
   endfunction

   task automatic send_bits(input logic [10:0] w, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk) ps2d = w[i];
         repeat (HALF) @(negedge clk);
         ps2c = 1'b0;
         repeat (HALF) @(negedge clk);
         ps2c = 1'b1;
      end
      @(negedge clk) ps2d = 1'b1;
      repeat (3 * HALF) @(negedge clk);
   endtask

   // spoil: 0 good, 1 parity, 2 start, 3 stop
   task automatic send_code(input logic [7:0] c, input int spoil);
      logic [10:0] w;
      logic        dig;
      logic [7:0]  p;
      w = {1'b1, ~^c, c, 1'b0};
      if (spoil == 1) w[9]  = ~w[9];
      if (spoil == 2) w[0]  = 1'b1;
      if (spoil == 3) w[10] = 1'b0;
      if (spoil == 0) begin
         p = ref_pattern(c, dig);
         if (model_break) model_break = 1'b0;
         else if (c == 8'hF0) model_break = 1'b1;
         else if (dig) begin
            exp_q.push_back(p[6:0]);
            last_seg = p[6:0];
         end
      end
      send_bits(w, 11);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && strobe) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R5 unexpected strobe", int'(seg), 0);
         end else begin
            logic [6:0] e;
            e = exp_q.pop_front();
            chk(seg == e, "R2 digit pattern", int'(seg), int'(e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] codes [10];
      codes = '{8'h45, 8'h16, 8'h1E, 8'h26, 8'h25, 8'h2E, 8'h36, 8'h3D, 8'h3E, 8'h46};
      repeat (5) @(negedge clk);
      chk(seg == 7'h00, "R8 reset segments", int'(seg), 0);
      chk(strobe == 1'b0, "R8 reset strobe", int'(strobe), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R2: every digit, LSB-first framing
      foreach (codes[i]) begin
         send_code(codes[i], 0);
         chk(seg == last_seg, "R1 digit shown", int'(seg), int'(last_seg));
      end

      // R3: spoiled frames
      send_code(8'h16, 1);
      chk(seg == last_seg, "R3 bad parity dropped", int'(seg), int'(last_seg));
      send_code(8'h1E, 2);
      chk(seg == last_seg, "R3 bad start dropped", int'(seg), int'(last_seg));
      send_code(8'h26, 3);
      chk(seg == last_seg, "R3 bad stop dropped", int'(seg), int'(last_seg));

      // R4: non-digit code
      send_code(8'h1C, 0);
      chk(seg == last_seg, "R4 non-digit ignored", int'(seg), int'(last_seg));

      // R5: release sequence
      send_code(8'h25, 0);
      send_code(8'hF0, 0);
      send_code(8'h16, 0);
      chk(seg == 7'h66, "R5 release byte ignored", int'(seg), 8'h66);
      send_code(8'h3D, 0);
      chk(seg == 7'h07, "R5 next press after release", int'(seg), 8'h07);

      // R6: truncated frame then idle gap
      send_bits(11'b0_1010_1100_0, 5);
      repeat (6000) @(negedge clk);
      send_code(8'h26, 0);
      chk(seg == 7'h4F, "R6 resync after timeout", int'(seg), 8'h4F);

      // R8: hold over idle time
      repeat (2000) @(negedge clk);
      chk(seg == 7'h4F, "R8 display held", int'(seg), 8'h4F);

      chk(exp_q.size() == 0, "R7 every digit strobed", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule